// File: doc/BRIEF.md
# Clock Divider Sync Controller

An integer clock divider whose phase can be pulled into line by an external, asynchronous sync pulse. The sync pulse is brought into the input clock domain and reduced to a single event on its rising edge. A three-bit control byte decides whether that event reaches the divider. On an event that gets through, the divider counter is forced back to zero, so every divider in a system that shares the sync pulse starts its period on the same input clock edge.

The control byte has a master enable, a separate divider-sync enable, and a mode bit. The mode bit picks between continuous realignment and single-shot realignment. In single-shot mode the hardware clears the divider-sync enable after the first alignment it performs. Software writes the enable again to re-arm. The divide ratio is a build-time parameter.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00. Bits 7..3 always read 0 and writes to them have no effect. Bits 2..0 read back the value last written, except where R5 clears bit 1.
- R2: The master enable is control bit 0. While it is 0, sync pulses never realign the divider.
- R3: The divider-sync enable is control bit 1. While it is 0, sync pulses never realign the divider, even when bit 0 is 1.
- R4: Continuous mode is control bits 2..0 = 0b011. Every sync rising edge realigns the divider, and bit 1 stays set.
- R5: Single-shot mode is control bits 2..0 = 0b111. The first sync rising edge realigns the divider and clears bit 1. Later pulses are then ignored until software sets bit 1 again.
- R6: A register write in the same cycle as the single-shot clear of bit 1 takes precedence. The written value is what the register holds afterwards.
- R7: The sync input passes through a two-flop synchroniser. One low-to-high transition is one event, however long the pulse stays high. The realignment happens on the third rising input clock edge after the sync input goes high.
- R8: The divided clock output is a register. It is high for ceil(N/2) input cycles and low for the remaining N - ceil(N/2) input cycles of each N-cycle period. On a realignment edge the counter goes to zero and the output goes high, which starts a new period.
- R9: With a divide ratio of 1, the output is the input clock itself, and sync has no visible effect.
- R10: Reset is synchronous and active high. While it is held, the control byte is 0x00 and the divided clock output is 1 (the start of a period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous sync pulse |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte readback |
| clk_div | output | 1 | Divided clock |

## Verification
The assertions assume two things about the inputs. Writes are single-cycle strobes with stable data in the clock domain. The sync input may change at any time relative to the clock but stays low or high long enough to be captured. The bench therefore drives every input, sync included, half a period after the active edge, and holds each sync level for at least one full cycle. The random phase mixes sparse writes of arbitrary bytes with sync pulses of random length. This lands events on every counter phase and makes writes coincide with single-shot clears.

// File: rtl/cdsync_pkg.sv
package cdsync_pkg;

    localparam int CTRL_BITS = 3;
    localparam int BYTE_W    = 8;

    typedef struct packed {
        logic oneshot;
        logic div_en;
        logic master;
    } sync_ctrl_t;

    function automatic sync_ctrl_t ctrl_unpack(input logic [BYTE_W-1:0] b);
        sync_ctrl_t c;
        c.oneshot = b[2];
        c.div_en  = b[1];
        c.master  = b[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_pack(input sync_ctrl_t c);
        return {{(BYTE_W-CTRL_BITS){1'b0}}, c};
    endfunction

    function automatic logic align_allowed(input sync_ctrl_t c);
        return c.master & c.div_en;
    endfunction

    function automatic int unsigned high_len(input int unsigned n);
        return (n + 1) / 2;
    endfunction

endpackage

// File: rtl/cdsync_edge.sv
module cdsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b0;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~last_q;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R7

endmodule

// File: rtl/cdsync_ctrl.sv
module cdsync_ctrl
    import cdsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              align_used,
    output sync_ctrl_t        ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= ctrl_unpack(wr_data);
        end else if (align_used && ctrl.oneshot) begin
            ctrl.div_en <= 1'b0;
        end
    end

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (align_used && ctrl.oneshot && !wr_en) |=> !ctrl.div_en);  // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl == ctrl_unpack($past(wr_data))));  // R6

    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ctrl.oneshot) |=> $stable(ctrl));  // R4

endmodule

// File: rtl/cdsync_div.sv
module cdsync_div
    import cdsync_pkg::*;
#(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic align,
    output logic div_q
);
    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);
    localparam logic [CNT_W:0]   HI_V = (CNT_W+1)'(high_len(RATIO));

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        if (align || cnt == LAST) nxt = '0;
        else                      nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= 1'b1;
        end else begin
            cnt   <= nxt;
            div_q <= ({1'b0, nxt} < HI_V);
        end
    end

    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        align |=> (cnt == '0 && div_q));  // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R8

endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
    import cdsync_pkg::*;
#(
    parameter int unsigned DIV_RATIO   = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_in,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        clk_div
);
    sync_ctrl_t ctrl;
    logic       rise;
    logic       align;
    logic       div_q;

    cdsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (rise)
    );

    assign align = rise & align_allowed(ctrl);

    cdsync_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .align_used (align),
        .ctrl       (ctrl)
    );

    cdsync_div #(.RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst   (rst),
        .align (align),
        .div_q (div_q)
    );

    assign rd_data = ctrl_pack(ctrl);

    generate
        if (DIV_RATIO <= 1) begin : g_pass
            assign clk_div = clk;
        end else begin : g_div
            assign clk_div = div_q;
        end
    endgenerate

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[0] && !wr_en) |=> !rd_data[0]);  // R2

endmodule

// File: tb/tb_clkdiv_sync_ctrl.sv
module tb_clkdiv_sync_ctrl;
    localparam int N  = 4;
    localparam int HI = (N + 1) / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, rd_data_r1;
    logic       clk_div, clk_div_r1;

    int checks = 0;
    int failures = 0;
    string tag = "R10";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_sync_ctrl #(.DIV_RATIO(N)) dut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .clk_div(clk_div));

    clkdiv_sync_ctrl #(.DIV_RATIO(1)) dut_r1 (
        .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data_r1), .clk_div(clk_div_r1));

    // reference model built from the requirements
    logic       m_s1, m_s2, m_s3, m_div;
    logic [2:0] m_ctrl;
    int         m_cnt;
    bit         started = 1'b0;

    function automatic int next_cnt(input int c, input logic ev);
        if (ev) return 0;
        return (c == N-1) ? 0 : c + 1;
    endfunction

    always @(posedge clk) begin
        logic ev;
        int   nc;
        started = 1'b1;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ctrl = 0; m_cnt = 0; m_div = 1;
        end else begin
            ev = m_s2 & ~m_s3 & m_ctrl[0] & m_ctrl[1];
            nc = next_cnt(m_cnt, ev);
            m_cnt = nc;
            m_div = (nc < HI);
            if (wr_en) m_ctrl = wr_data[2:0];
            else if (ev && m_ctrl[2]) m_ctrl[1] = 1'b0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_byte(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%02h exp=%02h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!started) return;
        check_bit("clk_div", clk_div, m_div);
        check_byte("rd_data", rd_data, {5'b0, m_ctrl});
    endtask

    // R9: ratio-1 instance follows the input clock
    always @(posedge clk) begin
        if (!rst && started && !done) begin
            #1;
            begin
                string sv = tag;
                tag = "R9";
                check_bit("pass-high", clk_div_r1, 1'b1);
                tag = sv;
            end
        end
    end

    task automatic cyc(input logic w, input logic [7:0] d, input logic s);
        @(negedge clk);
        compare();
        if (!rst) begin
            string sv = tag;
            tag = "R9";
            check_bit("pass-low", clk_div_r1, 1'b0);
            tag = sv;
        end
        wr_en = w; wr_data = d; sync_in = s;
    endtask

    task automatic idle(input int n, input logic s);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, s);
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b1, d, sync_in);
    endtask

    task automatic pulses(input int count);
        for (int k = 0; k < count; k++) begin
            idle(2 + k, 1'b1);
            idle(3 + 2*k, 1'b0);
        end
    endtask

    initial begin
        // R10: reset state
        tag = "R10";
        idle(3, 1'b0);
        check_byte("reset rd_data", rd_data, 8'h00);
        check_bit("reset clk_div", clk_div, 1'b1);
        @(negedge clk); rst = 1'b0;

        // R1: upper bits ignored, lower bits read back
        tag = "R1";
        wr(8'hF8); idle(1, 1'b0);
        check_byte("upper ignored", rd_data, 8'h00);
        wr(8'hFC); idle(1, 1'b0);
        check_byte("lower kept", rd_data, 8'h04);
        wr(8'h00); idle(2, 1'b0);

        // R2: master enable off
        tag = "R2";
        wr(8'h06); pulses(4);
        // R3: divider sync enable off
        tag = "R3";
        wr(8'h05); pulses(4);
        // R4: continuous mode
        tag = "R4";
        wr(8'h03); pulses(5);
        check_byte("bit1 kept", rd_data, 8'h03);
        // R5: single-shot
        tag = "R5";
        wr(8'h07); pulses(4);
        check_byte("bit1 cleared", rd_data, 8'h05);
        wr(8'h07); pulses(2);
        // R6: write coincides with self-clear
        tag = "R6";
        wr(8'h07); idle(1, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);          // sync high before edge A
        cyc(1'b0, 8'h00, 1'b1);          // edge A: first flop
        cyc(1'b1, 8'h07, 1'b1);          // edge B done: rise active, write presented
        idle(1, 1'b1);
        check_byte("write wins", rd_data, 8'h07);
        idle(4, 1'b0);
        // R7: long pulse is one event, latency of three edges
        tag = "R7";
        wr(8'h03); idle(N + 1, 1'b0);
        idle(25, 1'b1); idle(6, 1'b0);
        // R8: random mix
        tag = "R8";
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED_1234);
            for (int i = 0; i < 3000; i++) begin
                logic w;
                logic s;
                logic [7:0] d;
                w = ($urandom_range(0, 15) == 0);
                d = 8'($urandom);
                if ($urandom_range(0, 3) == 0) s = ~sync_in;
                else s = sync_in;
                cyc(w, d, s);
            end
        end
        idle(4, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 150000);
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule